// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Bank

This block is a small pool of waiting slots placed in front of one floating-point execution unit of a dynamically scheduled core. The issue stage hands it an operation together with, for each of the two sources, either a ready value or the 4-bit tag of the station that will produce that value. Tag zero means the value is already present. Each slot owns a fixed tag (`BASE_TAG` plus its index), so its eventual result can be found by the other banks.

Every cycle each occupied slot compares its pending source tags with the tag on the shared result broadcast bus. Any slot that matches copies the broadcast data in that same cycle. When both sources of a slot hold values, the slot is offered to the execution unit. If several slots are ready, the one issued earliest goes first. The unit takes one operation per cycle, and only while it reports itself idle. A slot stays occupied until its own tag appears on the broadcast bus. It then becomes free for a new issue, and the issue side sees the free slot through `issueReady`.

Top module: `rsb_bank`

## Requirements
- R1: After reset every slot is free: `issueReady` is 1 and `dispValid` is 0.
- R2: `issueReady` is 1 exactly when at least one slot is free. An issue is taken only in a cycle with `issueValid` and `issueReady` both 1. With all slots occupied, `issueValid` changes nothing.
- R3: At issue, a source whose tag is 0 stores the supplied value. A source with a nonzero tag stores the tag and waits for a broadcast.
- R4: A slot is offered on the dispatch port (`dispValid`, `dispOp`, `dispVj`, `dispVk`) only while both of its source tags are 0 and it has not been handed over yet. A hand-over happens in a cycle with `dispValid` and `unitIdle` both 1. The slot is then never offered again during the same occupancy.
- R5: In a cycle with `cdbValid` 1, every occupied slot whose pending source tag equals `cdbTag` loads `cdbData` into that source and clears the tag. All matching sources of all slots load together.
- R6: A slot is freed at the end of the cycle in which `cdbValid` is 1 and `cdbTag` equals the slot's own tag. It is available to issue from the next cycle on.
- R7: If an issued source names the tag that is on the broadcast bus in that same cycle, the broadcast data is stored as the value, and no wakeup is lost.
- R8: Among slots ready at once, the one issued earliest is offered first.
- R9: A new issue goes to the lowest-numbered free slot. Slot i has tag `BASE_TAG`+i, and that tag is shown on `dispTag` when the slot is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueOp | input | OP_W | Operation code |
| issueVj | input | DATA_W | First source value (used when issueQj is 0) |
| issueQj | input | 4 | First source producer tag, 0 = none |
| issueVk | input | DATA_W | Second source value (used when issueQk is 0) |
| issueQk | input | 4 | Second source producer tag, 0 = none |
| issueReady | output | 1 | A free slot exists |
| cdbValid | input | 1 | Broadcast bus carries a result |
| cdbTag | input | 4 | Tag of the broadcasting station |
| cdbData | input | DATA_W | Broadcast result |
| unitIdle | input | 1 | Execution unit can accept an operation |
| dispValid | output | 1 | A ready slot is offered |
| dispTag | output | 4 | Tag of the offered slot |
| dispOp | output | OP_W | Operation of the offered slot |
| dispVj | output | DATA_W | First operand of the offered slot |
| dispVk | output | DATA_W | Second operand of the offered slot |

## Verification
The assertions assume that a slot's own tag is broadcast only after that slot has been handed to the unit. They also assume that an issued source names an own-bank tag only while that slot is occupied. Finally, they assume that no two stations share a tag. The random stimulus respects all three. Completion broadcasts are drawn only from slots the reference model marks as handed over. Own-bank source tags are drawn only from occupied slots. Foreign producers use tags 8 to 11, which lie outside the bank's range.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  parameter int RSB_TAG_W = 4;
  typedef logic [RSB_TAG_W-1:0] rsbTag_t;
  localparam rsbTag_t RSB_NO_TAG = '0;

  // Per-slot strobes from control to datapath
  typedef struct packed {
    logic alloc;
    logic disp;
  } rsbEntStrobe_t;

  function automatic logic tagHit(rsbTag_t pend, logic busValid, rsbTag_t busTag);
    return busValid && (pend != RSB_NO_TAG) && (pend == busTag);
  endfunction
endpackage

// File: rtl/rsb_datapath.sv
module rsb_datapath
  import rsb_pkg::*;
#(
  parameter int NUM_ENT = 3,
  parameter int DATA_W  = 32,
  parameter int OP_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [OP_W-1:0]             issueOp,
  input  logic [DATA_W-1:0]           issueVj,
  input  rsbTag_t                     issueQj,
  input  logic [DATA_W-1:0]           issueVk,
  input  rsbTag_t                     issueQk,
  input  logic                        cdbValid,
  input  rsbTag_t                     cdbTag,
  input  logic [DATA_W-1:0]           cdbData,
  input  rsbEntStrobe_t [NUM_ENT-1:0] strb,
  output logic [NUM_ENT-1:0]          srcReady,
  output logic [OP_W-1:0]             dispOp,
  output logic [DATA_W-1:0]           dispVj,
  output logic [DATA_W-1:0]           dispVk
);
  logic [OP_W-1:0]   opQ [NUM_ENT];
  logic [DATA_W-1:0] vjQ [NUM_ENT];
  logic [DATA_W-1:0] vkQ [NUM_ENT];
  rsbTag_t           qjQ [NUM_ENT];
  rsbTag_t           qkQ [NUM_ENT];

  // Issue-time bypass: a source named on the bus this cycle is taken as a value
  logic    bypJ, bypK;
  assign bypJ = tagHit(issueQj, cdbValid, cdbTag);
  assign bypK = tagHit(issueQk, cdbValid, cdbTag);

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        opQ[i] <= '0;
        vjQ[i] <= '0;
        vkQ[i] <= '0;
        qjQ[i] <= RSB_NO_TAG;
        qkQ[i] <= RSB_NO_TAG;
      end else if (strb[i].alloc) begin
        opQ[i] <= issueOp;
        vjQ[i] <= bypJ ? cdbData : issueVj;
        qjQ[i] <= bypJ ? RSB_NO_TAG : issueQj;
        vkQ[i] <= bypK ? cdbData : issueVk;
        qkQ[i] <= bypK ? RSB_NO_TAG : issueQk;
      end else begin
        if (tagHit(qjQ[i], cdbValid, cdbTag)) begin
          vjQ[i] <= cdbData;
          qjQ[i] <= RSB_NO_TAG;
        end
        if (tagHit(qkQ[i], cdbValid, cdbTag)) begin
          vkQ[i] <= cdbData;
          qkQ[i] <= RSB_NO_TAG;
        end
      end
    end

    assign srcReady[i] = (qjQ[i] == RSB_NO_TAG) && (qkQ[i] == RSB_NO_TAG);

    // R5
    snoop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tagHit(qjQ[i], cdbValid, cdbTag) && !strb[i].alloc)
      |=> (qjQ[i] == RSB_NO_TAG) && (vjQ[i] == $past(cdbData)));

    // R7
    issue_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb[i].alloc && tagHit(issueQk, cdbValid, cdbTag))
      |=> (qkQ[i] == RSB_NO_TAG) && (vkQ[i] == $past(cdbData)));

    // R4
    disp_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb[i].disp |-> (qjQ[i] == RSB_NO_TAG) && (qkQ[i] == RSB_NO_TAG));
  end

  always_comb begin
    dispOp = '0;
    dispVj = '0;
    dispVk = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (strb[i].disp) begin
        dispOp = dispOp | opQ[i];
        dispVj = dispVj | vjQ[i];
        dispVk = dispVk | vkQ[i];
      end
    end
  end
endmodule

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
#(
  parameter int NUM_ENT  = 3,
  parameter int BASE_TAG = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issueValid,
  input  logic                        cdbValid,
  input  rsbTag_t                     cdbTag,
  input  logic                        unitIdle,
  input  logic [NUM_ENT-1:0]          srcReady,
  output logic                        issueReady,
  output logic                        dispValid,
  output rsbTag_t                     dispTag,
  output rsbEntStrobe_t [NUM_ENT-1:0] strb
);
  function automatic rsbTag_t ownTag(int idx);
    return rsbTag_t'(BASE_TAG + idx);
  endfunction

  logic [NUM_ENT-1:0] busy, sent, ready, freeHit, allocSel, dispSel, blocked;
  logic [NUM_ENT-1:0] older [NUM_ENT];  // older[j][i]: slot j issued before slot i
  logic issueFire, dispFire, seen;

  assign ready      = busy & ~sent & srcReady;
  assign issueReady = ~&busy;
  assign issueFire  = issueValid && issueReady;
  assign dispValid  = |ready;
  assign dispFire   = dispValid && unitIdle;

  always_comb begin
    seen     = 1'b0;
    allocSel = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (!busy[i] && !seen) begin
        allocSel[i] = 1'b1;
        seen        = 1'b1;
      end
    end
  end

  always_comb begin
    blocked = '0;
    dispTag = RSB_NO_TAG;
    for (int i = 0; i < NUM_ENT; i++) begin
      for (int j = 0; j < NUM_ENT; j++)
        if (j != i && ready[j] && older[j][i]) blocked[i] = 1'b1;
      dispSel[i] = ready[i] && !blocked[i];
      freeHit[i] = cdbValid && (cdbTag == ownTag(i));
      if (dispSel[i]) dispTag = ownTag(i);
    end
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_strb
    assign strb[i].alloc = allocSel[i] && issueFire;
    assign strb[i].disp  = dispSel[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      sent <= '0;
      for (int j = 0; j < NUM_ENT; j++) older[j] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (issueFire && allocSel[i]) begin
          busy[i] <= 1'b1;
          sent[i] <= 1'b0;
          for (int j = 0; j < NUM_ENT; j++) begin
            older[j][i] <= (j != i) && busy[j];
            older[i][j] <= 1'b0;
          end
        end else begin
          if (freeHit[i]) begin
            busy[i] <= 1'b0;
            sent[i] <= 1'b0;
          end else if (dispFire && dispSel[i]) begin
            sent[i] <= 1'b1;
          end
        end
      end
    end
  end

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&busy) && !cdbValid) |=> (&busy));

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_chk
    // R6
    free_on_own_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[i] && cdbValid && cdbTag == ownTag(i)) |=> !busy[i]);

    // R4
    single_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dispSel[i] && unitIdle) |=> !dispSel[i]);
  end

  // R8
  one_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |-> $onehot0(dispSel) && (dispSel != '0));
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank
  import rsb_pkg::*;
#(
  parameter int NUM_ENT  = 3,
  parameter int BASE_TAG = 1,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [DATA_W-1:0] issueVj,
  input  logic [3:0]        issueQj,
  input  logic [DATA_W-1:0] issueVk,
  input  logic [3:0]        issueQk,
  output logic              issueReady,
  input  logic              cdbValid,
  input  logic [3:0]        cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  input  logic              unitIdle,
  output logic              dispValid,
  output logic [3:0]        dispTag,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispVj,
  output logic [DATA_W-1:0] dispVk
);
  rsbEntStrobe_t [NUM_ENT-1:0] strb;
  logic [NUM_ENT-1:0]          srcReady;

  rsb_ctrl #(.NUM_ENT(NUM_ENT), .BASE_TAG(BASE_TAG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .cdbValid(cdbValid),
    .cdbTag(cdbTag), .unitIdle(unitIdle), .srcReady(srcReady),
    .issueReady(issueReady), .dispValid(dispValid), .dispTag(dispTag), .strb(strb)
  );

  rsb_datapath #(.NUM_ENT(NUM_ENT), .DATA_W(DATA_W), .OP_W(OP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .issueOp(issueOp), .issueVj(issueVj), .issueQj(issueQj),
    .issueVk(issueVk), .issueQk(issueQk), .cdbValid(cdbValid), .cdbTag(cdbTag),
    .cdbData(cdbData), .strb(strb), .srcReady(srcReady), .dispOp(dispOp),
    .dispVj(dispVj), .dispVk(dispVk)
  );
endmodule

// File: tb/rsb_bank_bench.sv
`timescale 1ns/1ps
module rsb_bank_bench;
  localparam int NE = 3;
  localparam int BT = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issueValid = 1'b0;
  logic [2:0]  issueOp = '0;
  logic [31:0] issueVj = '0, issueVk = '0, cdbData = '0;
  logic [3:0]  issueQj = '0, issueQk = '0, cdbTag = '0;
  logic        cdbValid = 1'b0, unitIdle = 1'b0;
  logic        issueReady, dispValid;
  logic [3:0]  dispTag;
  logic [2:0]  dispOp;
  logic [31:0] dispVj, dispVk;

  int checks = 0;
  int errors = 0;

  // Reference model
  logic        mBusy [NE];
  logic        mSent [NE];
  logic [2:0]  mOp   [NE];
  logic [31:0] mVj   [NE];
  logic [31:0] mVk   [NE];
  logic [3:0]  mQj   [NE];
  logic [3:0]  mQk   [NE];
  int          mSeq  [NE];
  int          seqCtr = 0;

  always #5 clk = ~clk;

  rsb_bank u_rsb_bank (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueOp(issueOp),
    .issueVj(issueVj), .issueQj(issueQj), .issueVk(issueVk), .issueQk(issueQk),
    .issueReady(issueReady), .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .unitIdle(unitIdle), .dispValid(dispValid), .dispTag(dispTag), .dispOp(dispOp),
    .dispVj(dispVj), .dispVk(dispVk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowestFree();
    for (int i = 0; i < NE; i++) if (!mBusy[i]) return i;
    return -1;
  endfunction

  function automatic int oldestReady();
    int sel = -1;
    for (int i = 0; i < NE; i++)
      if (mBusy[i] && !mSent[i] && mQj[i] == 0 && mQk[i] == 0)
        if (sel < 0 || mSeq[i] < mSeq[sel]) sel = i;
    return sel;
  endfunction

  function automatic logic hit(logic [3:0] q, logic v, logic [3:0] t);
    return v && q != 0 && q == t;
  endfunction

  task automatic step(input logic iv, input logic [2:0] op, input logic [31:0] vj,
                      input logic [3:0] qj, input logic [31:0] vk, input logic [3:0] qk,
                      input logic cv, input logic [3:0] ct, input logic [31:0] cd,
                      input logic idle);
    int fi, ds;
    @(negedge clk);
    issueValid = iv; issueOp = op; issueVj = vj; issueQj = qj; issueVk = vk; issueQk = qk;
    cdbValid = cv; cdbTag = ct; cdbData = cd; unitIdle = idle;
    #1;
    fi = lowestFree();
    ds = oldestReady();
    chk("R2 R6 issueReady", {31'b0, issueReady}, {31'b0, fi >= 0});
    chk("R4 dispValid", {31'b0, dispValid}, {31'b0, ds >= 0});
    if (ds >= 0) begin
      chk("R8 R9 dispTag", {28'b0, dispTag}, 32'(BT + ds));
      chk("R4 dispOp", {29'b0, dispOp}, {29'b0, mOp[ds]});
      chk("R3 R5 R7 dispVj", dispVj, mVj[ds]);
      chk("R3 R5 R7 dispVk", dispVk, mVk[ds]);
    end
    @(posedge clk);
    for (int i = 0; i < NE; i++) begin
      if (mBusy[i]) begin
        if (hit(mQj[i], cv, ct)) begin mVj[i] = cd; mQj[i] = 0; end
        if (hit(mQk[i], cv, ct)) begin mVk[i] = cd; mQk[i] = 0; end
        if (cv && ct == 4'(BT + i)) begin mBusy[i] = 0; mSent[i] = 0; end
      end
    end
    if (ds >= 0 && idle) mSent[ds] = 1;
    if (iv && fi >= 0) begin
      mBusy[fi] = 1; mSent[fi] = 0; mOp[fi] = op; mSeq[fi] = seqCtr++;
      if (hit(qj, cv, ct)) begin mVj[fi] = cd; mQj[fi] = 0; end
      else begin mVj[fi] = vj; mQj[fi] = qj; end
      if (hit(qk, cv, ct)) begin mVk[fi] = cd; mQk[fi] = 0; end
      else begin mVk[fi] = vk; mQk[fi] = qk; end
    end
  endtask

  function automatic logic [3:0] pickSrc();
    int r = $urandom % 8;
    int e;
    if (r < 4) return 4'd0;
    if (r < 6) return 4'(8 + $urandom % 4);
    e = $urandom % NE;
    return mBusy[e] ? 4'(BT + e) : 4'd0;
  endfunction

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [3:0] qj, qk, ct;
    logic cv;
    int e;
    for (int i = 0; i < NE; i++) begin
      mBusy[i] = 0; mSent[i] = 0; mOp[i] = 0; mVj[i] = 0; mVk[i] = 0;
      mQj[i] = 0; mQk[i] = 0; mSeq[i] = 0;
    end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 issueReady after reset", {31'b0, issueReady}, 32'd1);
    chk("R1 dispValid after reset", {31'b0, dispValid}, 32'd0);

    // Directed: fill all slots with foreign producers (R3, R9)
    step(1, 3'd1, 32'h11, 4'd9, 32'h12, 4'd0, 0, 0, 0, 0);
    step(1, 3'd2, 32'h21, 4'd0, 32'h22, 4'd9, 0, 0, 0, 0);
    step(1, 3'd3, 32'h31, 4'd10, 32'h32, 4'd10, 0, 0, 0, 0);
    // R2: full bank, issue ignored
    step(1, 3'd4, 32'h41, 4'd0, 32'h42, 4'd0, 0, 0, 0, 0);
    #1 chk("R2 full stall issueReady", {31'b0, issueReady}, 32'd0);
    // R5: one broadcast wakes two slots at once
    step(0, 0, 0, 0, 0, 0, 1, 4'd9, 32'hAAAA_0009, 0);
    // R8: both ready, oldest (slot 0, tag 1) offered; unit busy then idle
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    #1 chk("R8 oldest offered first", {28'b0, dispTag}, 32'd1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R6: free slot 0 via its own tag; slot 2 also wakes from tag 10
    step(0, 0, 0, 0, 0, 0, 1, 4'd1, 32'h0BAD_0001, 0);
    step(0, 0, 0, 0, 0, 0, 1, 4'd10, 32'hCCCC_000A, 0);
    #1 chk("R6 freed slot visible", {31'b0, issueReady}, 32'd1);
    // R7: issue naming the tag on the bus this cycle
    step(1, 3'd5, 32'h51, 4'd2, 32'h52, 4'd11, 1, 4'd11, 32'hDDDD_000B, 1);
    step(0, 0, 0, 0, 0, 0, 1, 4'd2, 32'hEEEE_0002, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      qj = pickSrc();
      qk = pickSrc();
      cv = 1'b0; ct = 4'd0;
      case ($urandom % 4)
        0: ;
        1, 2: begin cv = 1'b1; ct = 4'(8 + $urandom % 4); end
        default: begin
          e = $urandom % NE;
          if (mBusy[e] && mSent[e]) begin cv = 1'b1; ct = 4'(BT + e); end
        end
      endcase
      step(($urandom % 3) != 0, 3'($urandom), $urandom, qj, $urandom, qk,
           cv, ct, $urandom, ($urandom % 3) != 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule